// File: doc/BRIEF.md
# Counter Gate Source Router

This block forms the gate input of every counter channel in a ring of three-channel counter chips. Each channel owns a 5-bit gate select register. The selected code picks the channel's gate from one of several sources: a constant level, the channel's own gate pin (plain or inverted), the output of a neighbouring counter channel (plain or inverted), or one of three status signals derived from a pattern detector. The router latches two of those status signals itself. The same code also sets the direction of the channel's gate pin: the pin is an input only while it is selected as the gate source.

The neighbour used by the chained codes is channel n-2, counted around the ring. Channel 2 of a chip takes channel 0 of the same chip. Channels 0 and 1 take channel n+1 of the preceding chip, and the lowest chip treats the highest chip as its predecessor. The pattern-occurred flag goes high once the pattern-present input has been seen high. The pattern-gone flag rests high and drops once the pattern has occurred and then vanished. A synchronous clear input returns both flags to rest, and so does reset. A parameter picks the extended code set; with it off, every code above 3 is reserved.

Software addresses the select registers by chip and channel through a simple write port and a combinational read port.

Top module: `ctr_gate_router`

## Requirements
- R1: After reset every select register reads 0, so every gate is high and every gate pin is driven as an output (oe = 1).
- R2: Code 0 drives the gate high and code 1 drives it low, whatever the other inputs are.
- R3: Code 2 passes the channel's gate pin straight through and is the only code that clears that channel's pin output enable.
- R4: Code 3 gives the inverted output of channel n-2. For channel 2 that is channel 0 of the same chip. For channels 0 and 1 it is channel n+1 of the preceding chip, and chip 0 is preceded by the last chip. The flat channel index is chip*3 + channel.
- R5: With the extended set enabled, code 6 gives the inverted gate pin and code 7 gives the non-inverted output of channel n-2, using the same routing as R4.
- R6: Code 8 follows pattern-present combinationally and code 11 gives its inverse.
- R7: The occurred flag is set at the first clock edge that samples pattern-present high and then stays set. Code 9 shows the flag and code 12 shows its inverse.
- R8: The gone flag is high at rest. It falls at a clock edge where the occurred flag is set and pattern-present is low, and then stays low. Code 10 shows the flag and code 13 shows its inverse.
- R9: A clear sampled at a clock edge returns the occurred flag to 0 and the gone flag to 1, taking priority over setting the flags. Reset does the same.
- R10: Codes 4, 5 and 14 to 31 drive the gate low. With the extended set disabled, codes 6 to 13 do as well.
- R11: A write updates the addressed register at the clock edge, so the gate follows from the next cycle. A read returns the stored code combinationally. A read of channel index 3 returns 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Select register write strobe |
| wr_chip | input | CHIP_W | Chip index of the write |
| wr_chan | input | 2 | Channel index of the write (0..2) |
| wr_data | input | SEL_W | Code to store |
| rd_chip | input | CHIP_W | Chip index of the read |
| rd_chan | input | 2 | Channel index of the read |
| rd_data | output | SEL_W | Stored code, 0 for an invalid address |
| gate_pin_in | input | NCH | Dedicated gate pin of each channel |
| gate_pin_oe | output | NCH | 1 where the gate pin is driven by the board |
| ctr_out | input | NCH | Output of each counter channel |
| pat_present | input | 1 | Pattern-present status |
| pat_clear | input | 1 | Synchronous clear of both pattern flags |
| gate | output | NCH | Gate of each counter channel |

## Verification
On every cycle, the assertions check the constant codes, the reserved codes and the pin direction against the stored codes. They also check each write landing in its register, and the set, hold, fall and clear rules of the two pattern flags, including that the gone flag can only be low while the occurred flag is set. The ring routing of codes 3 and 7 and the pin inversion of code 6 can only be shown by the bench scenarios. Those scenarios drive counter-output patterns that tell every channel's source apart. The same holds for the combinational readback, the ignored write to channel index 3, and the flags surviving register rewrites after reset.

// File: rtl/ctr_gate_pkg.sv
package ctr_gate_pkg;
   localparam int CH_PER_CHIP = 3;
   localparam int CODE_HIGH   = 0;
   localparam int CODE_LOW    = 1;
   localparam int CODE_PIN    = 2;
   localparam int CODE_NOUT2  = 3;
   localparam int CODE_PIN_N  = 6;
   localparam int CODE_OUT2   = 7;
   localparam int CODE_PAT    = 8;
   localparam int CODE_OCC    = 9;
   localparam int CODE_GONE   = 10;
   localparam int CODE_PAT_N  = 11;
   localparam int CODE_OCC_N  = 12;
   localparam int CODE_GONE_N = 13;

   function automatic bit code_reserved(input int code, input bit ext);
      if (code <= CODE_NOUT2) return 1'b0;
      if (!ext) return 1'b1;
      return !(code == CODE_PIN_N || code == CODE_OUT2 ||
               (code >= CODE_PAT && code <= CODE_GONE_N));
   endfunction
endpackage

// File: rtl/gate_sel_regs.sv
module gate_sel_regs #(
   parameter int NCH   = 6,
   parameter int SEL_W = 5,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_hit,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [SEL_W-1:0] wr_data,
   output logic [SEL_W-1:0] sel_q [NCH]
);
   for (genvar k = 0; k < NCH; k++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            sel_q[k] <= '0;
         else if (wr_hit && (int'(wr_idx) == k))
            sel_q[k] <= wr_data;
      end
   end
endmodule

// File: rtl/pattern_latches.sv
module pattern_latches (
   input  logic clk,
   input  logic rst_n,
   input  logic pat_present,
   input  logic pat_clear,
   output logic occ,
   output logic gone
);
   always_ff @(posedge clk) begin
      if (!rst_n || pat_clear) begin
         occ  <= 1'b0;
         gone <= 1'b1;
      end else begin
         if (pat_present) occ <= 1'b1;
         if (occ && !pat_present) gone <= 1'b0;
      end
   end
endmodule

// File: rtl/gate_mux.sv
module gate_mux
   import ctr_gate_pkg::*;
#(
   parameter int SEL_W    = 5,
   parameter bit ENHANCED = 1'b1
) (
   input  logic [SEL_W-1:0] sel,
   input  logic             pin,
   input  logic             src_out,
   input  logic             pat,
   input  logic             occ,
   input  logic             gone,
   output logic             gate,
   output logic             pin_oe
);
   logic base_gate;
   logic ext_gate;

   assign pin_oe = (int'(sel) != CODE_PIN);

   always_comb begin
      case (int'(sel))
         CODE_HIGH:  base_gate = 1'b1;
         CODE_PIN:   base_gate = pin;
         CODE_NOUT2: base_gate = ~src_out;
         default:    base_gate = 1'b0;
      endcase
   end

   if (ENHANCED) begin : g_ext
      always_comb begin
         case (int'(sel))
            CODE_PIN_N:  ext_gate = ~pin;
            CODE_OUT2:   ext_gate = src_out;
            CODE_PAT:    ext_gate = pat;
            CODE_OCC:    ext_gate = occ;
            CODE_GONE:   ext_gate = gone;
            CODE_PAT_N:  ext_gate = ~pat;
            CODE_OCC_N:  ext_gate = ~occ;
            CODE_GONE_N: ext_gate = ~gone;
            default:     ext_gate = base_gate;
         endcase
      end
   end else begin : g_base
      assign ext_gate = base_gate;
   end

   assign gate = ext_gate;
endmodule

// File: rtl/ctr_gate_router.sv
module ctr_gate_router
   import ctr_gate_pkg::*;
#(
   parameter int NUM_CHIPS = 2,
   parameter int SEL_W     = 5,
   parameter bit ENHANCED  = 1'b1,
   localparam int NCH      = NUM_CHIPS * CH_PER_CHIP,
   localparam int CHIP_W   = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1,
   localparam int IDX_W    = $clog2(NCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CHIP_W-1:0] wr_chip,
   input  logic [1:0]        wr_chan,
   input  logic [SEL_W-1:0]  wr_data,
   input  logic [CHIP_W-1:0] rd_chip,
   input  logic [1:0]        rd_chan,
   output logic [SEL_W-1:0]  rd_data,
   input  logic [NCH-1:0]    gate_pin_in,
   output logic [NCH-1:0]    gate_pin_oe,
   input  logic [NCH-1:0]    ctr_out,
   input  logic              pat_present,
   input  logic              pat_clear,
   output logic [NCH-1:0]    gate
);
   if (NUM_CHIPS < 1 || NUM_CHIPS > 64) begin : g_bad_chips
      $error("ctr_gate_router: NUM_CHIPS out of range");
   end
   if (SEL_W < 4 || SEL_W > 8) begin : g_bad_sel
      $error("ctr_gate_router: SEL_W must be 4..8");
   end

   logic             wr_hit;
   logic [IDX_W-1:0] wr_idx;
   logic             rd_ok;
   logic [IDX_W-1:0] rd_idx;
   logic [SEL_W-1:0] sel_q [NCH];
   logic             pat_occ;
   logic             pat_gone;

   assign wr_hit = wr_en && (int'(wr_chip) < NUM_CHIPS) && (int'(wr_chan) < CH_PER_CHIP);
   assign wr_idx = IDX_W'(int'(wr_chip) * CH_PER_CHIP + int'(wr_chan));
   assign rd_ok  = (int'(rd_chip) < NUM_CHIPS) && (int'(rd_chan) < CH_PER_CHIP);
   assign rd_idx = IDX_W'(int'(rd_chip) * CH_PER_CHIP + int'(rd_chan));

   gate_sel_regs #(.NCH(NCH), .SEL_W(SEL_W), .IDX_W(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wr_idx(wr_idx),
      .wr_data(wr_data), .sel_q(sel_q)
   );

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NCH; k++)
         if (rd_ok && int'(rd_idx) == k) rd_data = sel_q[k];
   end

   pattern_latches u_pat (
      .clk(clk), .rst_n(rst_n), .pat_present(pat_present),
      .pat_clear(pat_clear), .occ(pat_occ), .gone(pat_gone)
   );

   for (genvar gc = 0; gc < NUM_CHIPS; gc++) begin : g_chip
      for (genvar gn = 0; gn < CH_PER_CHIP; gn++) begin : g_chan
         localparam int K   = gc * CH_PER_CHIP + gn;
         localparam int SRC = (gn == 2) ? gc * CH_PER_CHIP
                              : ((gc + NUM_CHIPS - 1) % NUM_CHIPS) * CH_PER_CHIP + gn + 1;
         gate_mux #(.SEL_W(SEL_W), .ENHANCED(ENHANCED)) u_mux (
            .sel(sel_q[K]), .pin(gate_pin_in[K]), .src_out(ctr_out[SRC]),
            .pat(pat_present), .occ(pat_occ), .gone(pat_gone),
            .gate(gate[K]), .pin_oe(gate_pin_oe[K])
         );
      end
   end
endmodule

// File: rtl/ctr_gate_router_chk.sv
module ctr_gate_router_chk
   import ctr_gate_pkg::*;
#(
   parameter int NCH      = 6,
   parameter int SEL_W    = 5,
   parameter int IDX_W    = 3,
   parameter bit ENHANCED = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_hit,
   input logic [IDX_W-1:0] wr_idx,
   input logic [SEL_W-1:0] wr_data,
   input logic [SEL_W-1:0] sel_q [NCH],
   input logic [NCH-1:0]   gate,
   input logic [NCH-1:0]   gate_pin_oe,
   input logic             pat_present,
   input logic             pat_clear,
   input logic             occ,
   input logic             gone
);
   for (genvar k = 0; k < NCH; k++) begin : g_ch
      assert_hold_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (int'(sel_q[k]) == CODE_HIGH) |-> gate[k]);
      assert_hold_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (int'(sel_q[k]) == CODE_LOW) |-> !gate[k]);
      assert_pin_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
         gate_pin_oe[k] == (int'(sel_q[k]) != CODE_PIN));
      assert_reserved_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
         code_reserved(int'(sel_q[k]), ENHANCED) |-> !gate[k]);
      assert_write_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_hit && int'(wr_idx) == k) |=> (sel_q[k] == $past(wr_data)));
   end

   assert_occ_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pat_present && !pat_clear) |=> occ);
   assert_occ_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (occ && !pat_clear) |=> occ);
   assert_gone_rest_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !occ |-> gone);
   assert_gone_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (occ && !pat_present && !pat_clear) |=> !gone);
   assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pat_clear |=> (!occ && gone));
endmodule

bind ctr_gate_router ctr_gate_router_chk #(
   .NCH(NCH), .SEL_W(SEL_W), .IDX_W(IDX_W), .ENHANCED(ENHANCED)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wr_idx(wr_idx),
   .wr_data(wr_data), .sel_q(sel_q), .gate(gate), .gate_pin_oe(gate_pin_oe),
   .pat_present(pat_present), .pat_clear(pat_clear), .occ(pat_occ), .gone(pat_gone)
);

// File: tb/ctr_gate_router_test.sv
module ctr_gate_router_test;
   localparam int NCHIP = 2;
   localparam int NCH   = 6;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           wr_en = 1'b0;
   logic [0:0]     wr_chip = '0;
   logic [1:0]     wr_chan = '0;
   logic [4:0]     wr_data = '0;
   logic [0:0]     rd_chip = '0;
   logic [1:0]     rd_chan = '0;
   logic [4:0]     rd_data;
   logic [NCH-1:0] gate_pin_in = '0;
   logic [NCH-1:0] gate_pin_oe;
   logic [NCH-1:0] ctr_out = '0;
   logic           pat_present = 1'b0;
   logic           pat_clear = 1'b0;
   logic [NCH-1:0] gate;

   int errs = 0;
   int checks = 0;

   always #4 clk = ~clk;

   ctr_gate_router #(.NUM_CHIPS(NCHIP), .SEL_W(5), .ENHANCED(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chip(wr_chip), .wr_chan(wr_chan),
      .wr_data(wr_data), .rd_chip(rd_chip), .rd_chan(rd_chan), .rd_data(rd_data),
      .gate_pin_in(gate_pin_in), .gate_pin_oe(gate_pin_oe), .ctr_out(ctr_out),
      .pat_present(pat_present), .pat_clear(pat_clear), .gate(gate)
   );

   task automatic check_vec(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic check_code(input string req, input logic [4:0] act, input logic [4:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int src_of(input int k);
      int chip = k / 3;
      int ch = k % 3;
      if (ch == 2) return chip * 3;
      return ((chip + NCHIP - 1) % NCHIP) * 3 + ch + 1;
   endfunction

   task automatic write_sel(input int chip, input int chan, input int code);
      @(negedge clk);
      wr_chip = 1'(chip);
      wr_chan = 2'(chan);
      wr_data = 5'(code);
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_all(input int code);
      for (int k = 0; k < NCH; k++) write_sel(k / 3, k % 3, code);
   endtask

   // pattern codes per channel: 0:9 1:12 2:10 3:13 4:8 5:11
   function automatic logic [NCH-1:0] pat_exp(input logic p, input logic o, input logic g);
      return {~p, p, ~g, g, ~o, o};
   endfunction

   task automatic load_pat_codes();
      write_sel(0, 0, 9);  write_sel(0, 1, 12); write_sel(0, 2, 10);
      write_sel(1, 0, 13); write_sel(1, 1, 8);  write_sel(1, 2, 11);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_vec("R1 gate after reset", gate, '1);
      check_vec("R1 oe after reset", gate_pin_oe, '1);
      for (int k = 0; k < NCH; k++) begin
         rd_chip = 1'(k / 3); rd_chan = 2'(k % 3); #1;
         check_code("R1 readback after reset", rd_data, 5'd0);
      end
   endtask

   task automatic t_const();
      gate_pin_in = '1; ctr_out = '1; pat_present = 1'b1;
      set_all(1); #1;
      check_vec("R2 code1 low", gate, '0);
      write_sel(0, 0, 0); write_sel(1, 1, 0); #1;
      check_vec("R2 mixed 0/1", gate, 6'b010001);
      gate_pin_in = '0; ctr_out = '0; pat_present = 1'b0; #1;
      check_vec("R2 inputs ignored", gate, 6'b010001);
   endtask

   task automatic t_pin();
      set_all(2);
      gate_pin_in = 6'b101100; #1;
      check_vec("R3 pin pass a", gate, 6'b101100);
      check_vec("R3 oe cleared", gate_pin_oe, '0);
      gate_pin_in = 6'b010011; #1;
      check_vec("R3 pin pass b", gate, 6'b010011);
      write_sel(1, 2, 0); #1;
      check_vec("R3 oe only for code2", gate_pin_oe, 6'b100000);
   endtask

   task automatic t_chain();
      logic [NCH-1:0] pats [3] = '{6'b000001, 6'b100110, 6'b011010};
      logic [NCH-1:0] exp;
      set_all(3);
      foreach (pats[i]) begin
         ctr_out = pats[i]; #1;
         for (int k = 0; k < NCH; k++) exp[k] = ~ctr_out[src_of(k)];
         check_vec("R4 inverted n-2 ring", gate, exp);
      end
      set_all(7);
      foreach (pats[i]) begin
         ctr_out = pats[i]; #1;
         for (int k = 0; k < NCH; k++) exp[k] = ctr_out[src_of(k)];
         check_vec("R5 true n-2 ring", gate, exp);
      end
      set_all(6);
      gate_pin_in = 6'b110010; #1;
      check_vec("R5 inverted pin", gate, 6'b001101);
   endtask

   task automatic t_present();
      for (int k = 0; k < NCH; k++) write_sel(k / 3, k % 3, (k % 2 == 0) ? 8 : 11);
      pat_present = 1'b1; #1;
      check_vec("R6 present high", gate, 6'b010101);
      pat_present = 1'b0; #1;
      check_vec("R6 present low", gate, 6'b101010);
   endtask

   task automatic t_latches();
      load_pat_codes();
      @(negedge clk); pat_clear = 1'b1;
      @(negedge clk); pat_clear = 1'b0; #1;
      check_vec("R9 rest after clear", gate, pat_exp(0, 0, 1));
      pat_present = 1'b1; #1;
      check_vec("R7 not yet latched", gate, pat_exp(1, 0, 1));
      @(negedge clk); #1;
      check_vec("R7 occurred set", gate, pat_exp(1, 1, 1));
      pat_present = 1'b0; #1;
      check_vec("R7 occurred holds", gate, pat_exp(0, 1, 1));
      @(negedge clk); #1;
      check_vec("R8 gone falls", gate, pat_exp(0, 1, 0));
      pat_present = 1'b1;
      @(negedge clk); #1;
      check_vec("R8 gone stays low", gate, pat_exp(1, 1, 0));
      pat_present = 1'b0;
   endtask

   task automatic t_clear();
      @(negedge clk); pat_clear = 1'b1;
      @(negedge clk); pat_clear = 1'b0; #1;
      check_vec("R9 clear restores", gate, pat_exp(0, 0, 1));
      pat_present = 1'b1; pat_clear = 1'b1;
      @(negedge clk); pat_clear = 1'b0; pat_present = 1'b0; #1;
      check_vec("R9 clear beats set", gate, pat_exp(0, 0, 1));
      pat_present = 1'b1;
      @(negedge clk); pat_present = 1'b0;
      @(negedge clk); #1;
      check_vec("R9 armed before reset", gate, pat_exp(0, 1, 0));
      rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      load_pat_codes(); #1;
      check_vec("R9 reset restores", gate, pat_exp(0, 0, 1));
   endtask

   task automatic t_reserved();
      int codes [6] = '{4, 5, 14, 15, 20, 31};
      gate_pin_in = '1; ctr_out = '1; pat_present = 1'b1;
      foreach (codes[i]) begin
         set_all(codes[i]); #1;
         check_vec($sformatf("R10 reserved code %0d", codes[i]), gate, '0);
      end
      gate_pin_in = '0; ctr_out = '0; pat_present = 1'b0;
   endtask

   task automatic t_readback();
      for (int k = 0; k < NCH; k++) write_sel(k / 3, k % 3, 17 + k);
      for (int k = 0; k < NCH; k++) begin
         rd_chip = 1'(k / 3); rd_chan = 2'(k % 3); #1;
         check_code("R11 readback", rd_data, 5'(17 + k));
      end
      write_sel(0, 3, 2); write_sel(1, 3, 2);
      for (int k = 0; k < NCH; k++) begin
         rd_chip = 1'(k / 3); rd_chan = 2'(k % 3); #1;
         check_code("R11 chan3 write ignored", rd_data, 5'(17 + k));
      end
      rd_chip = 1'b1; rd_chan = 2'd3; #1;
      check_code("R11 chan3 reads zero", rd_data, 5'd0);
      @(negedge clk);
      wr_chip = 1'b0; wr_chan = 2'd1; wr_data = 5'd1; wr_en = 1'b1; #1;
      check_vec("R11 gate before edge", gate[1:1], 1'b0);
      write_sel(0, 1, 0); #1;
      check_vec("R11 gate after edge", gate[1:1], 1'b1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_const();
      t_pin();
      t_chain();
      t_present();
      t_latches();
      t_clear();
      t_reserved();
      t_readback();
      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule